// File: doc/BRIEF.md
# Read-Sequence Command Unlock Detector

This block sits beside a static RAM port and watches every access presented to it. Software triggers a nonvolatile transfer without any dedicated command register: it reads a fixed chain of six addresses. Five of them form a shared prefix: 0x000, then 0x555, then 0x2AA, then 0x7FF, then 0x0F0. The sixth address chooses the command. A read at the recall key (default 0x70E) requests a RECALL, meaning that nonvolatile data is reloaded into the array. A read at the store key (default 0x70F) requests a STORE, meaning that the array is saved to nonvolatile cells. The first five reads complete as ordinary reads. Only the sixth one produces a request.

Any access that breaks the chain aborts it. Write accesses never advance the chain. A STORE request is withheld while the supply-good input is low. While the transfer engine reports busy, the detector ignores all accesses and returns to idle. Requests go out as single-cycle pulses on the clock edge after the access that completes the chain.

Top module: `seqcmd_detect`

## Requirements
- R1: After reset, `recall_req` and `store_req` are low and the chain is idle, so a lone read at the recall key requests nothing.
- R2: Reads accepted on consecutive accesses at 0x000, 0x555, 0x2AA, 0x7FF, 0x0F0 and then RECALL_KEY (default 0x70E) raise `recall_req` for exactly one cycle. The pulse appears on the clock edge after the final access is sampled.
- R3: The five prefix reads produce no request.
- R4: A read whose address differs from the next expected address aborts the chain. Later reads of the remaining addresses then request nothing.
- R5: If the aborting read is at 0x000, it counts as the first step of a new chain.
- R6: A write access aborts the chain and never advances it, even when its address matches the next expected one.
- R7: The five prefix reads followed by a read at STORE_KEY (default 0x70F), with `supply_ok` high at that read, raise `store_req` for exactly one cycle.
- R8: If `supply_ok` is low when the store-key read is sampled, no `store_req` is raised. The chain still returns to idle.
- R9: An access sampled while `engine_busy` is high is ignored, and the chain returns to idle. A sequence that has a busy step requests nothing.
- R10: Each request lasts a single cycle, and `recall_req` and `store_req` are never high together.
- R11: Cycles with `acc_valid` low do not disturb the chain. A sequence with idle gaps between its accesses still triggers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | One access is presented this cycle |
| acc_addr | input | 11 | Address of the access |
| acc_is_read | input | 1 | 1 = read access, 0 = write access |
| supply_ok | input | 1 | Supply above the switch threshold |
| engine_busy | input | 1 | Transfer engine is running a transfer |
| recall_req | output | 1 | One-cycle RECALL request pulse |
| store_req | output | 1 | One-cycle STORE request pulse |

## Verification
The assertions check the following on every cycle:
- The two requests are never high together, and each request lasts one cycle.
- A store request always follows a sample with the supply good.
- A recall request always follows a read at the recall key while the engine was idle.
- After a busy cycle or a write, the chain is back at idle.
- After a read of 0x000 that is not ignored, the chain is at step one.

Only the directed scenarios can show that the full ordered chain is needed. They also show that an abort at any point discards progress, that idle gaps are harmless, and that a store blocked by a low supply leaves nothing armed.

// File: rtl/seqcmd_pkg.sv
`timescale 1ns/1ps
package seqcmd_pkg;
    localparam int unsigned ADDR_W     = 11;
    localparam int unsigned PREFIX_LEN = 5;
    localparam int unsigned STEP_W     = $clog2(PREFIX_LEN + 1);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [STEP_W-1:0] step_t;

    // Shared prefix of both command chains, in the order it must be read
    function automatic addr_t prefix_key(input int unsigned idx);
        case (idx)
            0:       prefix_key = addr_t'(11'h000);
            1:       prefix_key = addr_t'(11'h555);
            2:       prefix_key = addr_t'(11'h2AA);
            3:       prefix_key = addr_t'(11'h7FF);
            default: prefix_key = addr_t'(11'h0F0);
        endcase
    endfunction

    typedef struct packed {
        step_t step;
    } chain_state_t;

    typedef struct packed {
        logic recall;
        logic store;
    } req_t;
endpackage

// File: rtl/seqcmd_match.sv
`timescale 1ns/1ps
module seqcmd_match
    import seqcmd_pkg::*;
#(
    parameter addr_t RECALL_KEY = addr_t'(11'h70E),
    parameter addr_t STORE_KEY  = addr_t'(11'h70F)
) (
    input  addr_t                 acc_addr,
    output logic [PREFIX_LEN-1:0] prefix_hit,
    output logic                  recall_hit,
    output logic                  store_hit
);
    // One comparator for each prefix step
    for (genvar g = 0; g < PREFIX_LEN; g++) begin : g_step
        assign prefix_hit[g] = (acc_addr == prefix_key(g));
    end

    assign recall_hit = (acc_addr == RECALL_KEY);
    assign store_hit  = (acc_addr == STORE_KEY);
endmodule

// File: rtl/seqcmd_chain.sv
`timescale 1ns/1ps
module seqcmd_chain
    import seqcmd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    input  logic                  acc_is_read,
    input  logic                  engine_busy,
    input  logic [PREFIX_LEN-1:0] prefix_hit,
    input  logic                  recall_hit,
    input  logic                  store_hit,
    output step_t                 step_q,
    output logic                  fire_recall,
    output logic                  fire_store
);
    localparam step_t LAST_STEP = step_t'(PREFIX_LEN);

    chain_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        fire_recall = 1'b0;
        fire_store  = 1'b0;
        if (engine_busy) begin
            st_d.step = '0;
        end else if (acc_valid) begin
            if (!acc_is_read) begin
                st_d.step = '0;
            end else if (st_q.step == LAST_STEP) begin
                fire_recall = recall_hit;
                fire_store  = store_hit && !recall_hit;
                if (!recall_hit && !store_hit && prefix_hit[0])
                    st_d.step = step_t'(1);
                else
                    st_d.step = '0;
            end else if (prefix_hit[st_q.step]) begin
                st_d.step = st_q.step + step_t'(1);
            end else if (prefix_hit[0]) begin
                st_d.step = step_t'(1);
            end else begin
                st_d.step = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign step_q = st_q.step;

    p_busy_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        engine_busy |=> (step_q == '0));

    p_write_no_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_is_read) |=> (step_q == '0));

    p_restart_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_is_read && !engine_busy && prefix_hit[0]) |=> (step_q == step_t'(1)));

    p_step_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step_q <= LAST_STEP);
endmodule

// File: rtl/seqcmd_issue.sv
`timescale 1ns/1ps
module seqcmd_issue
    import seqcmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_recall,
    input  logic fire_store,
    input  logic supply_ok,
    output logic recall_req,
    output logic store_req
);
    req_t req_d, req_q;

    always_comb begin
        req_d.recall = fire_recall;
        req_d.store  = fire_store && supply_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign recall_req = req_q.recall;
    assign store_req  = req_q.store;

    p_one_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(recall_req && store_req));

    p_recall_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |=> !recall_req);

    p_store_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |=> !store_req);

    p_store_supply_r8: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |-> $past(supply_ok));
endmodule

// File: rtl/seqcmd_detect.sv
`timescale 1ns/1ps
module seqcmd_detect
    import seqcmd_pkg::*;
#(
    parameter addr_t RECALL_KEY = addr_t'(11'h70E),
    parameter addr_t STORE_KEY  = addr_t'(11'h70F)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_is_read,
    input  logic              supply_ok,
    input  logic              engine_busy,
    output logic              recall_req,
    output logic              store_req
);
    logic [PREFIX_LEN-1:0] prefix_hit;
    logic                  recall_hit;
    logic                  store_hit;
    step_t                 step_q;
    logic                  fire_recall;
    logic                  fire_store;

    seqcmd_match #(
        .RECALL_KEY (RECALL_KEY),
        .STORE_KEY  (STORE_KEY)
    ) match_i (
        .acc_addr   (acc_addr),
        .prefix_hit (prefix_hit),
        .recall_hit (recall_hit),
        .store_hit  (store_hit)
    );

    seqcmd_chain chain_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_is_read (acc_is_read),
        .engine_busy (engine_busy),
        .prefix_hit  (prefix_hit),
        .recall_hit  (recall_hit),
        .store_hit   (store_hit),
        .step_q      (step_q),
        .fire_recall (fire_recall),
        .fire_store  (fire_store)
    );

    seqcmd_issue issue_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire_recall (fire_recall),
        .fire_store  (fire_store),
        .supply_ok   (supply_ok),
        .recall_req  (recall_req),
        .store_req   (store_req)
    );

    // A recall request must follow an accepted read of the recall key
    p_recall_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |-> $past(acc_valid && acc_is_read && !engine_busy
                             && (acc_addr == RECALL_KEY)));

    // A store request must follow an accepted read of the store key
    p_store_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |-> $past(acc_valid && acc_is_read && !engine_busy
                            && (acc_addr == STORE_KEY)));
endmodule

// File: tb/seqcmd_detect_tb.sv
`timescale 1ns/1ps
module seqcmd_detect_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [10:0] acc_addr = '0;
    logic        acc_is_read = 1'b1;
    logic        supply_ok = 1'b1;
    logic        engine_busy = 1'b0;
    logic        recall_req;
    logic        store_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    localparam logic [10:0] K_RECALL = 11'h70E;
    localparam logic [10:0] K_STORE  = 11'h70F;
    logic [10:0] pre [5] = '{11'h000, 11'h555, 11'h2AA, 11'h7FF, 11'h0F0};

    always #4 clk = ~clk;   // 125 MHz

    seqcmd_detect dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_addr    (acc_addr),
        .acc_is_read (acc_is_read),
        .supply_ok   (supply_ok),
        .engine_busy (engine_busy),
        .recall_req  (recall_req),
        .store_req   (store_req)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // One access, sampled at the next rising edge; returns at the following falling edge
    task automatic do_acc(input logic [10:0] a, input logic rd);
        acc_valid   = 1'b1;
        acc_addr    = a;
        acc_is_read = rd;
        @(negedge clk);
        acc_valid   = 1'b0;
        acc_is_read = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_none(input string tag);
        chk({tag, " recall"}, recall_req, 1'b0);
        chk({tag, " store"},  store_req,  1'b0);
    endtask

    task automatic prefix_reads(input string tag);
        for (int i = 0; i < 5; i++) begin
            do_acc(pre[i], 1'b1);
            expect_none({tag, " R3 prefix step"});
        end
    endtask

    task automatic t_reset;
        expect_none("R1 reset");
        do_acc(K_RECALL, 1'b1);
        expect_none("R1 lone key after reset");
        idle(1);
    endtask

    task automatic t_recall;
        prefix_reads("recall");
        do_acc(K_RECALL, 1'b1);
        chk("R2 recall pulse", recall_req, 1'b1);
        chk("R10 no store with recall", store_req, 1'b0);
        idle(1);
        chk("R10 recall single cycle", recall_req, 1'b0);
    endtask

    task automatic t_store;
        supply_ok = 1'b1;
        prefix_reads("store");
        do_acc(K_STORE, 1'b1);
        chk("R7 store pulse", store_req, 1'b1);
        chk("R10 no recall with store", recall_req, 1'b0);
        idle(1);
        chk("R10 store single cycle", store_req, 1'b0);
    endtask

    task automatic t_store_low;
        supply_ok = 1'b0;
        prefix_reads("low");
        do_acc(K_STORE, 1'b1);
        expect_none("R8 store blocked by low supply");
        supply_ok = 1'b1;
        do_acc(K_STORE, 1'b1);
        expect_none("R8 chain idle after blocked store");
        do_acc(K_RECALL, 1'b1);
        expect_none("R8 no recall after blocked store");
        idle(1);
    endtask

    task automatic t_abort;
        do_acc(pre[0], 1'b1);
        do_acc(pre[1], 1'b1);
        do_acc(11'h123, 1'b1);
        for (int i = 2; i < 5; i++) do_acc(pre[i], 1'b1);
        do_acc(K_RECALL, 1'b1);
        expect_none("R4 abort mid chain");
        prefix_reads("abort5");
        do_acc(pre[1], 1'b1);
        do_acc(K_RECALL, 1'b1);
        expect_none("R4 abort before final step");
        idle(1);
    endtask

    task automatic t_restart;
        do_acc(pre[0], 1'b1);
        do_acc(pre[1], 1'b1);
        do_acc(pre[0], 1'b1);   // breaks the chain but starts a new one
        for (int i = 1; i < 5; i++) do_acc(pre[i], 1'b1);
        do_acc(K_RECALL, 1'b1);
        chk("R5 restart on 0x000", recall_req, 1'b1);
        idle(1);
    endtask

    task automatic t_write;
        do_acc(pre[0], 1'b1);
        do_acc(pre[1], 1'b1);
        do_acc(pre[2], 1'b0);   // matching address, but a write
        for (int i = 2; i < 5; i++) do_acc(pre[i], 1'b1);
        do_acc(K_RECALL, 1'b1);
        expect_none("R6 write aborts");
        for (int i = 0; i < 5; i++) do_acc(pre[i], 1'b0);
        do_acc(K_RECALL, 1'b0);
        expect_none("R6 all-write chain");
        idle(1);
    endtask

    task automatic t_busy;
        do_acc(pre[0], 1'b1);
        do_acc(pre[1], 1'b1);
        engine_busy = 1'b1;
        do_acc(pre[2], 1'b1);
        engine_busy = 1'b0;
        for (int i = 3; i < 5; i++) do_acc(pre[i], 1'b1);
        do_acc(K_RECALL, 1'b1);
        expect_none("R9 busy step ignored");
        prefix_reads("busyfinal");
        engine_busy = 1'b1;
        do_acc(K_RECALL, 1'b1);
        engine_busy = 1'b0;
        expect_none("R9 busy final step");
        prefix_reads("afterbusy");
        do_acc(K_RECALL, 1'b1);
        chk("R9 works once busy clears", recall_req, 1'b1);
        idle(1);
    endtask

    task automatic t_gaps;
        for (int i = 0; i < 5; i++) begin
            do_acc(pre[i], 1'b1);
            idle(i + 1);
        end
        do_acc(K_STORE, 1'b1);
        chk("R11 gaps keep chain", store_req, 1'b1);
        idle(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_recall();
        t_store();
        t_store_low();
        t_abort();
        t_restart();
        t_write();
        t_busy();
        t_gaps();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule